// File: doc/BRIEF.md
# Timestamp Event Capture FIFO

This block stamps events with the current value of a free-running 64-bit time base and queues them for software. Event sources are a software capture request, counter rollover and half-rollover strobes, a bank of asynchronous hardware inputs, Ethernet receive and transmit strobes with their packet descriptors, a compare-match strobe and a host-transmit strobe. Each source owns one capture slot, so events that land in the same cycle are all held and then moved into the queue one per cycle in a fixed priority.

Software sees the queue head as four 32-bit words, a raw pending flag, an interrupt flag gated by an enable, and a sticky overflow flag. A one-cycle pop pulse discards the head. Per-input enables choose which hardware inputs produce events.

Top module: `ts_event_fifo`

## Requirements
- R1: After reset the queue is empty: `pend_raw`, `pend_irq` and `overflow` are 0 and all four event words read 0.
- R2: Word 1 of the head is {3'b0, port[4:0], kind[3:0], msg[3:0], seq[15:0]}, where kind is 0 software capture, 1 rollover, 2 half rollover, 3 hardware input, 4 receive, 5 transmit, 6 compare, 7 host transmit; message, sequence, domain and port are taken from the receive or transmit descriptor for kinds 4 and 5, and are 0 for the other kinds except the port of kind 3.
- R3: Word 0 holds time bits 31:0, word 3 holds time bits 63:32, and word 2 holds the domain number in bits 7:0 with bits 31:8 zero.
- R4: `pend_raw` is 1 exactly while the queue holds at least one entry; `pend_irq` equals `pend_raw` AND `int_en`.
- R5: A `pop` pulse removes the head entry; a `pop` pulse on an empty queue changes nothing.
- R6: A `sw_push` pulse sampled at a clock edge records the `cur_time` value sampled at that same edge; the entry becomes visible after the next edge.
- R7: A hardware input whose enable bit is set produces a kind-3 event on a rising edge seen through a two-flop synchronizer, stamped two edges after the input first reads high, with port equal to the input index plus 1; an input whose enable bit is clear produces nothing.
- R8: Events held together enter the queue in ascending kind order, hardware inputs among themselves in ascending input order, one entry per cycle.
- R9: The queue holds DEPTH (16) entries and returns them in arrival order.
- R10: An event whose turn comes while the queue is full is dropped, as is an event arriving at a source whose slot still holds an earlier event; either sets `overflow`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_time | input | 64 | Current time base value |
| sw_push | input | 1 | Software capture request |
| roll_evt | input | 1 | Counter rollover strobe |
| half_evt | input | 1 | Counter half-rollover strobe |
| hw_in | input | NUM_HW | Asynchronous hardware event inputs |
| hw_en | input | NUM_HW | Per-input capture enables |
| rx_evt | input | 1 | Receive packet strobe |
| rx_port | input | 5 | Receive port number |
| rx_msg | input | 4 | Receive message type |
| rx_seq | input | 16 | Receive sequence ID |
| rx_dom | input | 8 | Receive domain number |
| tx_evt | input | 1 | Transmit packet strobe |
| tx_port | input | 5 | Transmit port number |
| tx_msg | input | 4 | Transmit message type |
| tx_seq | input | 16 | Transmit sequence ID |
| tx_dom | input | 8 | Transmit domain number |
| cmp_evt | input | 1 | Compare match strobe |
| host_evt | input | 1 | Host transmit strobe |
| pop | input | 1 | Discard head entry |
| int_en | input | 1 | Interrupt enable |
| pend_raw | output | 1 | Queue not empty |
| pend_irq | output | 1 | Pending AND enable |
| overflow | output | 1 | Sticky drop flag |
| ev_word0 | output | 32 | Head time bits 31:0 |
| ev_word1 | output | 32 | Head port, kind, message, sequence |
| ev_word2 | output | 32 | Head domain |
| ev_word3 | output | 32 | Head time bits 63:32 |

## Verification
The two functions that meet in one cycle are event capture from several sources and the hand-over of the queue head, together with the queue filling at the same moment an event wins arbitration. The bench fires random subsets of all strobes in a single cycle, plus two enabled and one disabled hardware input rising together, then pops the queue and compares each entry with a bench model that sorts by kind and input index. A held software request keeps pushing past the queue capacity so the seventeenth grant meets a full queue, and the sixteen survivors are read back in time order.

// File: rtl/ts_evt_pkg.sv
package ts_evt_pkg;

   localparam int STAMP_W = 64;

   typedef enum logic [3:0] {
      EV_SWPUSH = 4'd0,
      EV_ROLL   = 4'd1,
      EV_HALF   = 4'd2,
      EV_HWPUSH = 4'd3,
      EV_RX     = 4'd4,
      EV_TX     = 4'd5,
      EV_CMP    = 4'd6,
      EV_HOST   = 4'd7
   } ev_kind_e;

   typedef struct packed {
      logic [STAMP_W-1:0] stamp;
      logic [4:0]         port;
      ev_kind_e           kind;
      logic [3:0]         msg;
      logic [15:0]        seq;
      logic [7:0]         dom;
   } ev_rec_t;

   function automatic logic [31:0] pack_info(ev_rec_t r);
      return {3'b000, r.port, r.kind, r.msg, r.seq};
   endfunction

endpackage

// File: rtl/ts_evt_edge.sv
module ts_evt_edge #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] async_in,
   input  logic [N-1:0] enable,
   output logic [N-1:0] rise
);

   initial begin
      if (N < 1) $error("ts_evt_edge: N must be at least 1");
   end

   for (genvar g = 0; g < N; g++) begin : g_in
      logic s1, s2, s3;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
         end else begin
            s1 <= async_in[g];
            s2 <= s1;
            s3 <= s2;
         end
      end
      assign rise[g] = s2 & ~s3 & enable[g];

      // R7: a pulse never lasts two cycles
      p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
         rise[g] |=> !rise[g]);
   end

endmodule

// File: rtl/ts_evt_arb.sv
module ts_evt_arb #(
   parameter int N = 15,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);

   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !any) begin
            gnt[i] = 1'b1;
            idx    = IW'(i);
            any    = 1'b1;
         end
      end
   end

   p_gnt_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   p_gnt_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|(gnt & req)));

endmodule

// File: rtl/ts_evt_store.sv
module ts_evt_store
   import ts_evt_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wr,
   input  ev_rec_t wdata,
   input  logic    rd,
   output logic    full,
   output logic    empty,
   output ev_rec_t head
);

   initial begin
      if (DEPTH < 2 || (1 << AW) != DEPTH)
         $error("ts_evt_store: DEPTH must be a power of two >= 2");
   end

   ev_rec_t       mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_wr, do_rd;

   assign full  = (cnt == (AW+1)'(DEPTH));
   assign empty = (cnt == '0);
   assign do_wr = wr & ~full;
   assign do_rd = rd & ~empty;
   assign head  = mem[rp];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_wr) wp <= wp + 1'b1;
         if (do_rd) rp <= rp + 1'b1;
         cnt <= cnt + (AW+1)'(do_wr) - (AW+1)'(do_rd);
      end
   end

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (AW+1)'(DEPTH));
   p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !wr) |=> empty);

endmodule

// File: rtl/ts_event_fifo.sv
module ts_event_fifo
   import ts_evt_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int NUM_HW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [63:0]       cur_time,
   input  logic              sw_push,
   input  logic              roll_evt,
   input  logic              half_evt,
   input  logic [NUM_HW-1:0] hw_in,
   input  logic [NUM_HW-1:0] hw_en,
   input  logic              rx_evt,
   input  logic [4:0]        rx_port,
   input  logic [3:0]        rx_msg,
   input  logic [15:0]       rx_seq,
   input  logic [7:0]        rx_dom,
   input  logic              tx_evt,
   input  logic [4:0]        tx_port,
   input  logic [3:0]        tx_msg,
   input  logic [15:0]       tx_seq,
   input  logic [7:0]        tx_dom,
   input  logic              cmp_evt,
   input  logic              host_evt,
   input  logic              pop,
   input  logic              int_en,
   output logic              pend_raw,
   output logic              pend_irq,
   output logic              overflow,
   output logic [31:0]       ev_word0,
   output logic [31:0]       ev_word1,
   output logic [31:0]       ev_word2,
   output logic [31:0]       ev_word3
);

   localparam int I_HW0  = 3;
   localparam int I_RX   = I_HW0 + NUM_HW;
   localparam int I_TX   = I_RX + 1;
   localparam int I_CMP  = I_RX + 2;
   localparam int I_HOST = I_RX + 3;
   localparam int NSRC   = I_RX + 4;
   localparam int IW     = $clog2(NSRC);

   initial begin
      if (NUM_HW < 1 || NUM_HW > 30)
         $error("ts_event_fifo: NUM_HW must be 1..30");
   end

   logic [NUM_HW-1:0] hw_rise;
   logic [NSRC-1:0]   src_evt, slot_v, gnt;
   ev_rec_t           src_rec [NSRC];
   ev_rec_t           slot_r  [NSRC];
   logic [IW-1:0]     gidx;
   logic              gany, q_full, q_empty, collide;
   ev_rec_t           q_head;

   ts_evt_edge #(.N(NUM_HW)) u_edge (
      .clk(clk), .rst_n(rst_n), .async_in(hw_in), .enable(hw_en), .rise(hw_rise)
   );

   always_comb begin
      for (int i = 0; i < NSRC; i++) begin
         src_rec[i]       = '0;
         src_rec[i].stamp = cur_time;
      end
      src_rec[0].kind      = EV_SWPUSH;
      src_rec[1].kind      = EV_ROLL;
      src_rec[2].kind      = EV_HALF;
      for (int h = 0; h < NUM_HW; h++) begin
         src_rec[I_HW0+h].kind = EV_HWPUSH;
         src_rec[I_HW0+h].port = 5'(h + 1);
      end
      src_rec[I_RX]        = '{stamp: cur_time, port: rx_port, kind: EV_RX,
                               msg: rx_msg, seq: rx_seq, dom: rx_dom};
      src_rec[I_TX]        = '{stamp: cur_time, port: tx_port, kind: EV_TX,
                               msg: tx_msg, seq: tx_seq, dom: tx_dom};
      src_rec[I_CMP].kind  = EV_CMP;
      src_rec[I_HOST].kind = EV_HOST;
   end

   assign src_evt = {host_evt, cmp_evt, tx_evt, rx_evt, hw_rise, half_evt, roll_evt, sw_push};

   for (genvar s = 0; s < NSRC; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_v[s] <= 1'b0;
         end else begin
            slot_v[s] <= src_evt[s] | (slot_v[s] & ~gnt[s]);
         end
      end
      always_ff @(posedge clk) begin
         if (src_evt[s] && (!slot_v[s] || gnt[s])) slot_r[s] <= src_rec[s];
      end

      // R8: a granted slot without a new event empties
      p_slot_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt[s] && !src_evt[s]) |=> !slot_v[s]);
   end

   ts_evt_arb #(.N(NSRC)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(slot_v), .gnt(gnt), .idx(gidx), .any(gany)
   );

   ts_evt_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .wr(gany), .wdata(slot_r[gidx]),
      .rd(pop), .full(q_full), .empty(q_empty), .head(q_head)
   );

   assign collide = |(src_evt & slot_v & ~gnt);

   always_ff @(posedge clk) begin
      if (!rst_n) overflow <= 1'b0;
      else if (collide || (gany && q_full)) overflow <= 1'b1;
   end

   assign pend_raw = ~q_empty;
   assign pend_irq = pend_raw & int_en;
   assign ev_word0 = q_empty ? 32'd0 : q_head.stamp[31:0];
   assign ev_word1 = q_empty ? 32'd0 : pack_info(q_head);
   assign ev_word2 = q_empty ? 32'd0 : {24'd0, q_head.dom};
   assign ev_word3 = q_empty ? 32'd0 : q_head.stamp[63:32];

   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   p_irq_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_irq |-> pend_raw);
   p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gany && q_full) |=> overflow);

endmodule

// File: tb/ts_event_fifo_bench.sv
module ts_event_fifo_bench;

   localparam int NHW = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, sw_push, roll_evt, half_evt, rx_evt, tx_evt, cmp_evt, host_evt, pop, int_en;
   logic [63:0] cur_time;
   logic [NHW-1:0] hw_in, hw_en;
   logic [4:0]  rx_port, tx_port;
   logic [3:0]  rx_msg, tx_msg;
   logic [15:0] rx_seq, tx_seq;
   logic [7:0]  rx_dom, tx_dom;
   logic pend_raw, pend_irq, overflow;
   logic [31:0] ev_word0, ev_word1, ev_word2, ev_word3;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   ts_event_fifo u_ts_event_fifo (
      .clk, .rst_n, .cur_time, .sw_push, .roll_evt, .half_evt, .hw_in, .hw_en,
      .rx_evt, .rx_port, .rx_msg, .rx_seq, .rx_dom,
      .tx_evt, .tx_port, .tx_msg, .tx_seq, .tx_dom,
      .cmp_evt, .host_evt, .pop, .int_en,
      .pend_raw, .pend_irq, .overflow, .ev_word0, .ev_word1, .ev_word2, .ev_word3
   );

   always @(posedge clk) cur_time <= cur_time + 64'd1;

   function automatic logic [31:0] w1(input logic [4:0] port, input logic [3:0] kind,
                                      input logic [3:0] msg, input logic [15:0] seq);
      return {3'b000, port, kind, msg, seq};
   endfunction

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pop_check(input string tag, input logic [63:0] t, input logic [31:0] e1,
                            input logic [7:0] dom);
      chk({tag, " pend_raw R4"}, 128'(pend_raw), 128'(1));
      chk(tag, {ev_word3, ev_word2, ev_word1, ev_word0},
          {t[63:32], 24'd0, dom, e1, t[31:0]});
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
   endtask

   task automatic clear_strobes();
      sw_push = 0; roll_evt = 0; half_evt = 0; rx_evt = 0; tx_evt = 0;
      cmp_evt = 0; host_evt = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] t0, t1;
      void'($urandom(32'h5eed_0417));
      cur_time = 64'h0000_0001_FFFF_FFF0;
      rst_n = 0; pop = 0; int_en = 0; hw_in = '0; hw_en = '0;
      clear_strobes();
      rx_port = 0; rx_msg = 0; rx_seq = 0; rx_dom = 0;
      tx_port = 0; tx_msg = 0; tx_seq = 0; tx_dom = 0;
      idle(4);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk("R1 flags", 128'({pend_raw, pend_irq, overflow}), 128'(0));
      chk("R1 words", {ev_word3, ev_word2, ev_word1, ev_word0}, 128'(0));

      // R6 software capture, R4 interrupt gating
      t0 = cur_time; sw_push = 1; @(negedge clk); sw_push = 0;
      chk("R6 not yet visible", 128'(pend_raw), 128'(0));
      @(negedge clk);
      chk("R4 irq masked", 128'({pend_raw, pend_irq}), 128'(2'b10));
      int_en = 1; #1;
      chk("R4 irq enabled", 128'(pend_irq), 128'(1));
      pop_check("R6 R3 sw capture", t0, 32'd0, 8'd0);
      chk("R4 empty after pop", 128'({pend_raw, pend_irq}), 128'(0));

      // R2 R3 receive descriptor fields
      rx_port = 5'd17; rx_msg = 4'hB; rx_seq = 16'hA55A; rx_dom = 8'hC3;
      t0 = cur_time; rx_evt = 1; @(negedge clk); rx_evt = 0; idle(2);
      pop_check("R2 R3 rx fields", t0, w1(5'd17, 4'd4, 4'hB, 16'hA55A), 8'hC3);

      // R5 pop on empty queue
      pop = 1; @(negedge clk); pop = 0; idle(1);
      chk("R5 empty pop", 128'(pend_raw), 128'(0));
      t0 = cur_time; sw_push = 1; @(negedge clk); sw_push = 0; idle(2);
      pop_check("R5 queue intact after empty pop", t0, 32'd0, 8'd0);
      chk("R5 single entry", 128'(pend_raw), 128'(0));

      // R7 R8 hardware inputs: 2 and 5 enabled, 0 disabled, all rise together
      hw_en = 8'b0010_0100;
      idle(4);
      t1 = cur_time + 64'd2;
      hw_in = 8'b0010_0101;
      idle(6);
      pop_check("R7 R8 hw input 2", t1, w1(5'd3, 4'd3, 4'd0, 16'd0), 8'd0);
      pop_check("R7 R8 hw input 5", t1, w1(5'd6, 4'd3, 4'd0, 16'd0), 8'd0);
      chk("R7 disabled input ignored", 128'(pend_raw), 128'(0));
      hw_in = '0; hw_en = '0; idle(4);

      // R8 R2 random simultaneous strobes against a sorted model
      for (int r = 0; r < 40; r++) begin
         logic [6:0] m;
         m = 7'($urandom);
         if (m == 0) m = 7'h01;
         rx_port = 5'($urandom); rx_msg = 4'($urandom); rx_seq = 16'($urandom); rx_dom = 8'($urandom);
         tx_port = 5'($urandom); tx_msg = 4'($urandom); tx_seq = 16'($urandom); tx_dom = 8'($urandom);
         {host_evt, cmp_evt, tx_evt, rx_evt, half_evt, roll_evt, sw_push} = m;
         t0 = cur_time;
         @(negedge clk);
         clear_strobes();
         idle(8);
         if (m[0]) pop_check("R8 rand kind 0", t0, w1(0, 4'd0, 0, 0), 0);
         if (m[1]) pop_check("R8 rand kind 1", t0, w1(0, 4'd1, 0, 0), 0);
         if (m[2]) pop_check("R8 rand kind 2", t0, w1(0, 4'd2, 0, 0), 0);
         if (m[3]) pop_check("R8 R2 rand rx", t0, w1(rx_port, 4'd4, rx_msg, rx_seq), rx_dom);
         if (m[4]) pop_check("R8 R2 rand tx", t0, w1(tx_port, 4'd5, tx_msg, tx_seq), tx_dom);
         if (m[5]) pop_check("R8 rand kind 6", t0, w1(0, 4'd6, 0, 0), 0);
         if (m[6]) pop_check("R8 rand kind 7", t0, w1(0, 4'd7, 0, 0), 0);
         chk("R8 rand drained", 128'(pend_raw), 128'(0));
      end

      // R9 R10 fill past capacity
      chk("R10 no overflow yet", 128'(overflow), 128'(0));
      t0 = cur_time; sw_push = 1; idle(17); sw_push = 0; idle(3);
      chk("R10 overflow set", 128'(overflow), 128'(1));
      for (int k = 0; k < 16; k++)
         pop_check("R9 fill order", t0 + 64'(k), 32'd0, 8'd0);
      chk("R9 R10 seventeenth dropped", 128'(pend_raw), 128'(0));
      idle(3);
      chk("R10 overflow sticky", 128'(overflow), 128'(1));

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule